// File: doc/BRIEF.md
# Main Register File Read-Port Arbiter

This block sits after the operand cache lookup of an out-of-order backend and decides which operands that missed the cache may use the few read ports of the main register file. Every cycle it takes, for each operand slot, a valid bit, a hit bit and the register number. Operands that hit need no port. Operands that miss are given ports in fixed priority order, lowest slot first. For each port it reports the register number to read and the slot that the returned data belongs to.

Two pipeline styles are supported through a mode parameter. In the miss-assumed style, every instruction already passes through fixed main-file read stages, so a hit or a miss costs the same. The backend is frozen only when more operands miss in one cycle than there are ports. In the stall-on-miss style, instructions are scheduled as if every operand hits. Any miss therefore freezes the backend until the main file has been read. In both styles, misses that get no port in the first cycle are granted on the following cycles while the backend is frozen. A frozen backend cannot reschedule work, so the whole operand group waits.

Top module: `mrf_read_arbiter`

## Requirements
- R1: While reset is high and in the first cycle after reset, `gnt_vld` is all zero and `stall` is low.
- R2: An operand with its hit bit set never receives a port; a group in which every valid operand hits produces no grant and no stall.
- R3: In miss-assumed mode, a group with at most NPORT misses has all of them granted in one cycle, with `stall` staying low.
- R4: Grant ports fill from port 0 upward. Port p carries the p-th lowest missing slot that is still pending. Its slot index appears in binary in `gnt_slot[p*SW +: SW]`, and that slot's register number (taken from `opnd_reg[s*RW +: RW]`) appears in `gnt_reg[p*RW +: RW]`.
- R5: In miss-assumed mode, a group with n misses is granted over ceil(n/NPORT) consecutive cycles, with all ports busy in every cycle except possibly the last. `stall` is high in every one of these cycles except the last, where it is low.
- R6: While `stall` is high, the operand inputs are ignored. After the group drains, nothing sampled during the stall is granted.
- R7: In stall-on-miss mode, any miss raises `stall` from the first grant cycle through the last grant cycle and for RD_LAT further cycles. That is ceil(n/NPORT)+RD_LAT stall cycles for n misses.
- R8: A slot with its valid bit low never receives a port, whatever its hit bit.
- R9: Grants for a group appear in the cycle after the group is sampled at a clock edge with `stall` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opnd_vld | input | NSLOT | Operand slot carries a source operand |
| opnd_hit | input | NSLOT | Operand was found in the operand cache |
| opnd_reg | input | NSLOT*RW | Register number per slot, slot s at bits [s*RW +: RW] |
| gnt_vld | output | NPORT | Read port p is used this cycle |
| gnt_reg | output | NPORT*RW | Register number to read on each port |
| gnt_slot | output | NPORT*SW | Operand slot the data of each port belongs to |
| stall | output | 1 | Backend freeze request |

## Verification
The bench sweeps every combination of valid and hit bits across four slots in both modes. It compares each cycle of the drain with grant lists and stall lengths worked out from the miss count. The corner cases it targets are as follows:
- Exactly NPORT misses. A design that compares with the wrong bound would stall one cycle when it should not.
- A lone miss in a high slot. A design that grants in the wrong priority order would put it on the wrong port.
- Misses that reach the last drain cycle. A design that releases the stall one cycle late or early would be out of step with the grants.
- Conventional-mode misses. A design that drops the read-latency tail would unfreeze too early.

While the block stalls, the bench drives a full set of misses on the inputs. A design that sampled inputs during the stall would emit stray grants after draining.

// File: rtl/rfa_pkg.sv
package rfa_pkg;
  typedef enum logic {
    ARB_MISS_ASSUMED = 1'b0,
    ARB_STALL_ANY    = 1'b1
  } arb_mode_e;
endpackage

// File: rtl/rfa_port_picker.sv
module rfa_port_picker #(
  parameter int NSLOT = 4,
  parameter int NPORT = 2,
  parameter int SW    = 2
) (
  input  logic [NSLOT-1:0]    req,
  output logic [NPORT-1:0]    pick_vld,
  output logic [NPORT*SW-1:0] pick_slot,
  output logic [NSLOT-1:0]    taken
);
  // lowest requesting slot takes port 0, next one port 1, and so on
  always_comb begin
    int n;
    n         = 0;
    pick_vld  = '0;
    pick_slot = '0;
    taken     = '0;
    for (int s = 0; s < NSLOT; s++) begin
      if (req[s] && n < NPORT) begin
        pick_vld[n]           = 1'b1;
        pick_slot[n*SW +: SW] = SW'(s);
        taken[s]              = 1'b1;
        n                     = n + 1;
      end
    end
  end
endmodule

// File: rtl/rfa_stall_ctrl.sv
module rfa_stall_ctrl
  import rfa_pkg::*;
#(
  parameter arb_mode_e MODE   = ARB_MISS_ASSUMED,
  parameter int        RD_LAT = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic any_pick,
  input  logic rem_any,
  output logic stall_q
);
  localparam int WW = (RD_LAT > 0) ? $clog2(RD_LAT + 1) : 1;

  generate
    if (MODE == ARB_STALL_ANY) begin : g_conv
      logic [WW-1:0] wait_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          stall_q <= 1'b0;
          wait_q  <= '0;
        end else if (any_pick) begin
          // grant cycle: stay frozen, then cover the read latency
          stall_q <= 1'b1;
          wait_q  <= WW'(RD_LAT);
        end else if (stall_q) begin
          stall_q <= (wait_q != '0);
          wait_q  <= (wait_q != '0) ? wait_q - 1'b1 : '0;
        end else begin
          stall_q <= 1'b0;
          wait_q  <= '0;
        end
      end
    end else begin : g_assume
      // read stages are always present: freeze only on leftover misses
      always_ff @(posedge clk) begin
        if (rst) stall_q <= 1'b0;
        else     stall_q <= rem_any;
      end
    end
  endgenerate
endmodule

// File: rtl/mrf_read_arbiter.sv
module mrf_read_arbiter
  import rfa_pkg::*;
#(
  parameter int        NSLOT  = 4,
  parameter int        NPORT  = 2,
  parameter int        NREG   = 128,
  parameter int        RD_LAT = 2,
  parameter arb_mode_e MODE   = ARB_MISS_ASSUMED,
  localparam int       RW     = $clog2(NREG),
  localparam int       SW     = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NSLOT-1:0]    opnd_vld,
  input  logic [NSLOT-1:0]    opnd_hit,
  input  logic [NSLOT*RW-1:0] opnd_reg,
  output logic [NPORT-1:0]    gnt_vld,
  output logic [NPORT*RW-1:0] gnt_reg,
  output logic [NPORT*SW-1:0] gnt_slot,
  output logic                stall
);
  logic [NSLOT-1:0]    pend_q;
  logic [NSLOT*RW-1:0] pend_reg_q;
  logic [NSLOT-1:0]    src_mask, taken, rem;
  logic [NSLOT*RW-1:0] src_reg;
  logic [NPORT-1:0]    pick_vld;
  logic [NPORT*SW-1:0] pick_slot;
  logic                stall_q;
  logic [NPORT-1:0]    gnt_vld_q;
  logic [NPORT*RW-1:0] gnt_reg_q;
  logic [NPORT*SW-1:0] gnt_slot_q;

  // new group only when the backend moves; otherwise drain leftovers
  assign src_mask = stall_q ? pend_q     : (opnd_vld & ~opnd_hit);
  assign src_reg  = stall_q ? pend_reg_q : opnd_reg;
  assign rem      = src_mask & ~taken;

  rfa_port_picker #(.NSLOT(NSLOT), .NPORT(NPORT), .SW(SW)) u_picker (
    .req      (src_mask),
    .pick_vld (pick_vld),
    .pick_slot(pick_slot),
    .taken    (taken)
  );

  rfa_stall_ctrl #(.MODE(MODE), .RD_LAT(RD_LAT)) u_stall (
    .clk     (clk),
    .rst     (rst),
    .any_pick(|pick_vld),
    .rem_any (|rem),
    .stall_q (stall_q)
  );

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= rem;
    if (!stall_q) pend_reg_q <= opnd_reg;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_vld_q  <= '0;
      gnt_reg_q  <= '0;
      gnt_slot_q <= '0;
    end else begin
      gnt_vld_q <= pick_vld;
      for (int p = 0; p < NPORT; p++) begin
        gnt_slot_q[p*SW +: SW] <= pick_slot[p*SW +: SW];
        gnt_reg_q[p*RW +: RW]  <= src_reg[pick_slot[p*SW +: SW]*RW +: RW];
      end
    end
  end

  assign gnt_vld  = gnt_vld_q;
  assign gnt_reg  = gnt_reg_q;
  assign gnt_slot = gnt_slot_q;
  assign stall    = stall_q;

  // ports fill from 0 upward in rising slot order
  generate
    for (genvar p = 1; p < NPORT; p++) begin : g_order_chk
      p_packed_ports_r4: assert property (@(posedge clk) disable iff (rst)
        gnt_vld_q[p] |-> (gnt_vld_q[p-1] &&
          (gnt_slot_q[p*SW +: SW] > gnt_slot_q[(p-1)*SW +: SW])));
    end
    if (MODE == ARB_MISS_ASSUMED) begin : g_assume_chk
      p_full_ports_when_stalled_r5: assert property (@(posedge clk) disable iff (rst)
        stall_q |-> (&gnt_vld_q));
      p_drain_continues_r5: assert property (@(posedge clk) disable iff (rst)
        stall_q |=> (|gnt_vld_q));
    end else begin : g_conv_chk
      p_grant_inside_stall_r7: assert property (@(posedge clk) disable iff (rst)
        (|gnt_vld_q) |-> stall_q);
      p_stall_after_miss_r7: assert property (@(posedge clk) disable iff (rst)
        (!stall_q && |(opnd_vld & ~opnd_hit)) |=> stall_q);
    end
  endgenerate
endmodule

// File: tb/mrf_read_arbiter_bench.sv
`timescale 1ns/1ps
module mrf_read_arbiter_bench;
  localparam int NS  = 4;
  localparam int NP  = 2;
  localparam int NR  = 128;
  localparam int LAT = 2;
  localparam int RW  = 7;
  localparam int SW  = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [NS-1:0]    in_vld [2];
  logic [NS-1:0]    in_hit [2];
  logic [NS*RW-1:0] in_reg [2];
  logic [NP-1:0]    o_vld  [2];
  logic [NP*RW-1:0] o_reg  [2];
  logic [NP*SW-1:0] o_slot [2];
  logic             o_stall[2];

  int  checks = 0;
  int  errors = 0;
  bit  done   = 1'b0;

  mrf_read_arbiter #(.NSLOT(NS), .NPORT(NP), .NREG(NR), .RD_LAT(LAT),
    .MODE(rfa_pkg::ARB_MISS_ASSUMED)) u_mrf_read_arbiter (
    .clk(clk), .rst(rst), .opnd_vld(in_vld[0]), .opnd_hit(in_hit[0]),
    .opnd_reg(in_reg[0]), .gnt_vld(o_vld[0]), .gnt_reg(o_reg[0]),
    .gnt_slot(o_slot[0]), .stall(o_stall[0]));

  mrf_read_arbiter #(.NSLOT(NS), .NPORT(NP), .NREG(NR), .RD_LAT(LAT),
    .MODE(rfa_pkg::ARB_STALL_ANY)) u_mrf_read_arbiter_conv (
    .clk(clk), .rst(rst), .opnd_vld(in_vld[1]), .opnd_hit(in_hit[1]),
    .opnd_reg(in_reg[1]), .gnt_vld(o_vld[1]), .gnt_reg(o_reg[1]),
    .gnt_slot(o_slot[1]), .stall(o_stall[1]));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_idle(input int m);
    in_vld[m] = '0; in_hit[m] = '0; in_reg[m] = '0;
  endtask

  // every slot valid and missing: would produce grants if not ignored (R6)
  task automatic set_junk(input int m);
    in_vld[m] = '1; in_hit[m] = '0;
    for (int s = 0; s < NS; s++) in_reg[m][s*RW +: RW] = RW'(NR - 1 - s);
  endtask

  task automatic run_group(input int m, input logic [NS-1:0] v,
                           input logic [NS-1:0] h, input logic [NS*RW-1:0] r);
    int lst[NS];
    int n, g, ncyc, idx;
    bit st_e;
    n = 0;
    for (int s = 0; s < NS; s++)
      if (v[s] && !h[s]) begin lst[n] = s; n++; end  // R2, R8: only valid misses
    g    = (n + NP - 1) / NP;
    ncyc = g + LAT + 1;
    in_vld[m] = v; in_hit[m] = h; in_reg[m] = r;
    for (int j = 0; j < ncyc; j++) begin
      @(posedge clk); @(negedge clk);
      // R9: group sampled at one edge, grants seen from the next cycle on
      st_e = (m == 0) ? (j < g - 1) : (n > 0 && j < g + LAT);
      for (int p = 0; p < NP; p++) begin
        idx = j * NP + p;
        if (idx < n) begin
          check((m == 0 && n <= NP) ? "R3 grant valid" : "R4 grant valid",
                int'(o_vld[m][p]), 1);
          check("R4 grant slot", int'(o_slot[m][p*SW +: SW]), lst[idx]);
          check("R4 grant reg", int'(o_reg[m][p*RW +: RW]),
                int'(r[lst[idx]*RW +: RW]));
        end else begin
          check((j >= g && j > 0) ? "R6 no stray grant" : "R2 R8 no grant",
                int'(o_vld[m][p]), 0);
        end
      end
      check((m == 0) ? "R5 stall" : "R7 stall", int'(o_stall[m]), int'(st_e));
      if (st_e) set_junk(m);
      else      set_idle(m);
    end
  endtask

  initial begin
    set_junk(0); set_junk(1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int m = 0; m < 2; m++) begin
      check("R1 reset gnt_vld", int'(o_vld[m]), 0);
      check("R1 reset stall", int'(o_stall[m]), 0);
    end
    set_idle(0); set_idle(1);
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    for (int m = 0; m < 2; m++) begin
      check("R1 post-reset gnt_vld", int'(o_vld[m]), 0);
      check("R1 post-reset stall", int'(o_stall[m]), 0);
    end
    for (int m = 0; m < 2; m++)
      for (int v = 0; v < (1 << NS); v++)
        for (int h = 0; h < (1 << NS); h++) begin
          logic [NS*RW-1:0] r;
          for (int s = 0; s < NS; s++)
            r[s*RW +: RW] = RW'((v * 37 + h * 19 + s * 53 + 11) % NR);
          run_group(m, NS'(v), NS'(h), r);
        end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule